// File: doc/BRIEF.md
# Load-Store Disambiguation Unit

This block sits between address generation and the data cache. It holds every store that is in flight, from allocation until commit. For each load presented to it, the block decides one of three outcomes: the load waits, it takes its value straight from an older buffered store, or it goes to memory ahead of older stores whose addresses are not yet known. The third outcome is a guess. It is steered by a small table of one-bit predictors. Each predictor remembers whether a given load ran into a store dependence the last time it executed.

A load that was allowed past unresolved stores is kept in a small tracker. The tracker holds it until every one of those stores has resolved its address. If one of them resolves to the load's own address, the guess was wrong. The block then pulses a flush request that names the load and drops all speculative tracking. The pipeline recovery itself happens outside the block.

Every store that is in the buffer when a load is presented counts as older than that load. The load request and the result are valid/ready streams:
- A load is taken only in a cycle where `ld_valid` and `ld_ready` are both high. `ld_ready` depends on the load's own fields, so it may fall while `ld_valid` is held.
- A result stays on the outputs, unchanged, while `res_valid` is high and `res_ready` is low.
- Store allocation is a valid/ready pair. The address, commit and flush pins are plain control pins.

Top module: `ldst_disambig`

## Requirements
- R1: The store buffer has 8 slots filled in program order. `st_alloc_ready` is high exactly when fewer than 8 stores are held. An accepted allocation is given slot `st_alloc_idx`, which then advances by one modulo 8.
- R2: `st_commit` removes the oldest store only if that store's address is known. A commit aimed at a store with an unknown address, or made when the buffer is empty, is ignored.
- R3: A non-I/O load whose older stores all have known addresses, and which matches one or more of them, is answered with `res_fwd`=1 and `res_spec`=0. It carries the data of the youngest matching store and makes no memory access.
- R4: A non-I/O load whose older stores all have known addresses, and which matches none of them, is answered with `res_fwd`=0, `res_spec`=0, `res_data`=0 and its own address on `res_addr`.
- R5: A load with `ld_io`=1 is held (`ld_ready`=0) while any buffered store has an unknown address or the same address as the load. Once accepted, it is never forwarded and never speculative.
- R6: A non-I/O load that finds one or more older stores with unknown addresses is held while its predictor bit is 1.
- R7: If that predictor bit is 0, the load is accepted with `res_spec`=1. It is forwarded from the youngest known match if there is one, and otherwise issued to memory. It is tracked against the stores that were unresolved when it was accepted.
- R8: The predictor has 16 one-bit entries, indexed by `ld_id[3:0]`, all 0 after reset. A non-speculative load, when accepted, writes 1 if it matched a store and 0 if it did not. A detected conflict writes 1 for the conflicting load.
- R9: A store address that resolves onto a tracked load which waited for that store, and which has the same address, pulses `flush_req` for one cycle in the following cycle. `flush_id` carries that load's ID; if several loads conflict, the one in the lowest tracker slot (slots fill lowest-free first) is reported. All tracking is cleared.
- R10: A load is not accepted in a cycle where `st_addr_valid` is high, while a result is being held, or when it would be speculative and all 4 tracker slots are in use.
- R11: While `res_valid`=1 and `res_ready`=0, every result output holds its value.
- R12: After reset, the buffer is empty, `st_alloc_idx`=0, `st_alloc_ready`=1, `res_valid`=0 and `flush_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_alloc_valid | input | 1 | Request a new store slot |
| st_alloc_ready | output | 1 | A slot is free |
| st_alloc_idx | output | 3 | Slot that the next allocation receives |
| st_addr_valid | input | 1 | Resolve a store's address and data |
| st_addr_idx | input | 3 | Slot being resolved |
| st_addr | input | 32 | Resolved store address |
| st_data | input | 32 | Store data |
| st_commit | input | 1 | Retire the oldest store |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request accepted this cycle |
| ld_addr | input | 32 | Load address |
| ld_id | input | 8 | Load identifier |
| ld_io | input | 1 | Load targets the memory-mapped I/O region |
| res_valid | output | 1 | Load outcome valid |
| res_ready | input | 1 | Consumer takes the outcome |
| res_fwd | output | 1 | 1: data forwarded from a store; 0: issue to memory |
| res_spec | output | 1 | Load passed unresolved stores |
| res_id | output | 8 | Load identifier |
| res_addr | output | 32 | Load address |
| res_data | output | 32 | Forwarded data, 0 when issued |
| flush_req | output | 1 | One-cycle flush request on a conflict |
| flush_id | output | 8 | Identifier of the conflicting load |

## Verification
The assertions rely on three things about the inputs:
- An address resolution names a slot that holds a store whose address is still unknown. A resolution aimed at any other slot is ignored by the logic, but it must not be counted on to create a conflict.
- `res_ready` is the only means of stalling the result stream.
- `st_addr_idx` is always in range.

The random stimulus picks the slot to resolve from the bench's own record of unresolved slots most of the time, and aims at a random slot only now and then. It draws load addresses from a small pool, so that matches, forwards and conflicts happen often. Back-pressure is applied only through `res_ready`.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int ID_W   = 8;

  typedef struct packed {
    logic              fwd;
    logic              spec;
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ld_out_t;
endpackage

// File: rtl/ldst_stq.sv
module ldst_stq #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_valid,
  output logic                         alloc_ready,
  output logic [$clog2(DEPTH)-1:0]     alloc_idx,
  input  logic                         rs_valid,
  input  logic [$clog2(DEPTH)-1:0]     rs_idx,
  input  logic [AW-1:0]                rs_addr,
  input  logic [DW-1:0]                rs_data,
  output logic                         rs_take,
  input  logic                         commit,
  input  logic [AW-1:0]                lk_addr,
  output logic [DEPTH-1:0]             lk_unknown,
  output logic                         lk_hit,
  output logic [DW-1:0]                lk_data
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]         v_q, k_q;
  logic [DEPTH-1:0][AW-1:0] a_q;
  logic [DEPTH-1:0][DW-1:0] d_q;
  logic [IW-1:0]            head_q, tail_q;
  logic [CW-1:0]            cnt_q;
  logic                     pop, push;

  assign alloc_ready = (cnt_q < CW'(DEPTH));
  assign alloc_idx   = tail_q;
  assign push        = alloc_valid && alloc_ready;
  assign pop         = commit && v_q[head_q] && k_q[head_q];
  assign rs_take     = rs_valid && v_q[rs_idx] && !k_q[rs_idx];

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Per-slot unknown-address flags
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_unk
      assign lk_unknown[g] = v_q[g] && !k_q[g];
    end
  endgenerate

  // Youngest known match: scan oldest to youngest, last hit wins
  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int j;
      j = (int'(head_q) + i) % DEPTH;
      if (v_q[j] && k_q[j] && a_q[j] == lk_addr) begin
        lk_hit  = 1'b1;
        lk_data = d_q[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= '0;
      k_q    <= '0;
      a_q    <= '0;
      d_q    <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop) begin
        v_q[head_q] <= 1'b0;
        k_q[head_q] <= 1'b0;
        head_q      <= bump(head_q);
      end
      if (push) begin
        v_q[tail_q] <= 1'b1;
        k_q[tail_q] <= 1'b0;
        tail_q      <= bump(tail_q);
      end
      if (rs_take) begin
        k_q[rs_idx] <= 1'b1;
        a_q[rs_idx] <= rs_addr;
        d_q[rs_idx] <= rs_data;
      end
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assert_commit_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit && v_q[head_q] && !k_q[head_q] |=> v_q[$past(head_q)]);
endmodule

// File: rtl/ldst_dep_pred.sv
module ldst_dep_pred #(
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic                       rd_bit,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic                       wr_bit
);
  logic [ENTRIES-1:0] tbl_q;

  assign rd_bit = tbl_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)     tbl_q <= '0;
    else if (wr_en) tbl_q[wr_idx] <= wr_bit;
  end

  assert_pred_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl_q[$past(wr_idx)] == $past(wr_bit));
endmodule

// File: rtl/ldst_spec_trk.sv
module ldst_spec_trk #(
  parameter int DEPTH = 4,
  parameter int SQ    = 8,
  parameter int AW    = 32,
  parameter int IDW   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_en,
  input  logic [AW-1:0]          alloc_addr,
  input  logic [IDW-1:0]         alloc_id,
  input  logic [SQ-1:0]          alloc_mask,
  input  logic                   rs_en,
  input  logic [$clog2(SQ)-1:0]  rs_idx,
  input  logic [AW-1:0]          rs_addr,
  output logic                   full,
  output logic                   busy,
  output logic                   viol,
  output logic [IDW-1:0]         viol_id
);
  logic [DEPTH-1:0]          v_q;
  logic [DEPTH-1:0][AW-1:0]  a_q;
  logic [DEPTH-1:0][IDW-1:0] id_q;
  logic [DEPTH-1:0][SQ-1:0]  m_q;
  logic [DEPTH-1:0]          hit;
  logic [$clog2(DEPTH)-1:0]  free_slot;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = rs_en && v_q[g] && m_q[g][rs_idx] && (a_q[g] == rs_addr);
    end
  endgenerate

  assign full = &v_q;
  assign busy = |v_q;
  assign viol = |hit;

  always_comb begin
    viol_id   = '0;
    free_slot = '0;
    for (int t = DEPTH - 1; t >= 0; t--) begin
      if (hit[t])  viol_id   = id_q[t];
      if (!v_q[t]) free_slot = t[$clog2(DEPTH)-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= '0;
      a_q  <= '0;
      id_q <= '0;
      m_q  <= '0;
    end else if (viol) begin
      v_q <= '0;
    end else begin
      if (rs_en) begin
        for (int t = 0; t < DEPTH; t++) begin
          logic [SQ-1:0] nm;
          nm = m_q[t] & ~(SQ'(1) << rs_idx);
          m_q[t] <= nm;
          if (nm == '0) v_q[t] <= 1'b0;
        end
      end
      if (alloc_en && !full) begin
        v_q[free_slot]  <= 1'b1;
        a_q[free_slot]  <= alloc_addr;
        id_q[free_slot] <= alloc_id;
        m_q[free_slot]  <= alloc_mask;
      end
    end
  end

  assert_viol_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !busy);
  assert_no_alloc_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);
endmodule

// File: rtl/ldst_disambig.sv
module ldst_disambig
  import ldst_pkg::*;
#(
  parameter int STQ_DEPTH = 8,
  parameter int TRK_DEPTH = 4,
  parameter int HIST_N    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          st_alloc_valid,
  output logic                          st_alloc_ready,
  output logic [$clog2(STQ_DEPTH)-1:0]  st_alloc_idx,
  input  logic                          st_addr_valid,
  input  logic [$clog2(STQ_DEPTH)-1:0]  st_addr_idx,
  input  logic [ADDR_W-1:0]             st_addr,
  input  logic [DATA_W-1:0]             st_data,
  input  logic                          st_commit,
  input  logic                          ld_valid,
  output logic                          ld_ready,
  input  logic [ADDR_W-1:0]             ld_addr,
  input  logic [ID_W-1:0]               ld_id,
  input  logic                          ld_io,
  output logic                          res_valid,
  input  logic                          res_ready,
  output logic                          res_fwd,
  output logic                          res_spec,
  output logic [ID_W-1:0]               res_id,
  output logic [ADDR_W-1:0]             res_addr,
  output logic [DATA_W-1:0]             res_data,
  output logic                          flush_req,
  output logic [ID_W-1:0]               flush_id
);
  localparam int HIW = $clog2(HIST_N);

  logic [STQ_DEPTH-1:0] unk;
  logic                 hit, rs_take, any_unk, pred_bit;
  logic [DATA_W-1:0]    hit_data;
  logic                 trk_full, trk_busy, viol;
  logic [ID_W-1:0]      viol_id;
  logic                 stall, spec, fwd, out_free, ld_acc;
  logic                 pw_en, pw_bit;
  logic [HIW-1:0]       pw_idx;
  ld_out_t              out_q;
  logic                 out_v_q, flush_q;
  logic [ID_W-1:0]      flush_id_q;

  ldst_stq #(.DEPTH(STQ_DEPTH), .AW(ADDR_W), .DW(DATA_W)) stq_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(st_alloc_valid), .alloc_ready(st_alloc_ready), .alloc_idx(st_alloc_idx),
    .rs_valid(st_addr_valid), .rs_idx(st_addr_idx), .rs_addr(st_addr), .rs_data(st_data),
    .rs_take(rs_take), .commit(st_commit),
    .lk_addr(ld_addr), .lk_unknown(unk), .lk_hit(hit), .lk_data(hit_data)
  );

  ldst_dep_pred #(.ENTRIES(HIST_N)) pred_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ld_id[HIW-1:0]), .rd_bit(pred_bit),
    .wr_en(pw_en), .wr_idx(pw_idx), .wr_bit(pw_bit)
  );

  ldst_spec_trk #(.DEPTH(TRK_DEPTH), .SQ(STQ_DEPTH), .AW(ADDR_W), .IDW(ID_W)) trk_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(ld_acc && spec), .alloc_addr(ld_addr), .alloc_id(ld_id), .alloc_mask(unk),
    .rs_en(rs_take), .rs_idx(st_addr_idx), .rs_addr(st_addr),
    .full(trk_full), .busy(trk_busy), .viol(viol), .viol_id(viol_id)
  );

  assign any_unk = |unk;

  // Outcome selection for the presented load
  always_comb begin
    stall = 1'b0;
    spec  = 1'b0;
    fwd   = 1'b0;
    if (ld_io) begin
      stall = any_unk || hit;
    end else if (any_unk) begin
      stall = pred_bit;
      spec  = !pred_bit;
      fwd   = hit && !pred_bit;
    end else begin
      fwd = hit;
    end
  end

  assign out_free = !out_v_q || res_ready;
  assign ld_ready = !stall && out_free && !st_addr_valid && !(spec && trk_full);
  assign ld_acc   = ld_valid && ld_ready;

  // Predictor write: conflicts take priority; they never share a cycle with a load
  always_comb begin
    pw_en  = 1'b0;
    pw_idx = ld_id[HIW-1:0];
    pw_bit = 1'b0;
    if (viol) begin
      pw_en  = 1'b1;
      pw_idx = viol_id[HIW-1:0];
      pw_bit = 1'b1;
    end else if (ld_acc && !spec) begin
      pw_en  = 1'b1;
      pw_bit = hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v_q    <= 1'b0;
      out_q      <= '0;
      flush_q    <= 1'b0;
      flush_id_q <= '0;
    end else begin
      if (ld_acc) begin
        out_v_q    <= 1'b1;
        out_q.fwd  <= fwd;
        out_q.spec <= spec;
        out_q.id   <= ld_id;
        out_q.addr <= ld_addr;
        out_q.data <= fwd ? hit_data : '0;
      end else if (out_free) begin
        out_v_q <= 1'b0;
      end
      flush_q <= viol;
      if (viol) flush_id_q <= viol_id;
    end
  end

  assign res_valid = out_v_q;
  assign res_fwd   = out_q.fwd;
  assign res_spec  = out_q.spec;
  assign res_id    = out_q.id;
  assign res_addr  = out_q.addr;
  assign res_data  = out_q.data;
  assign flush_req = flush_q;
  assign flush_id  = flush_id_q;

  assert_io_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready && ld_io |=> res_valid && !res_fwd && !res_spec);
  assert_hold_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_id)
      && $stable(res_addr) && $stable(res_fwd) && $stable(res_spec));
  assert_resolve_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_addr_valid |-> !ld_ready);
  assert_flush_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);
  assert_spec_tracked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready && !ld_io && any_unk |=> trk_busy && res_spec);
  assert_stall_pred_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_io && any_unk && pred_bit |-> !ld_ready);
endmodule

// File: tb/ldst_disambig_tb.sv
module ldst_disambig_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        st_alloc_valid = 0, st_alloc_ready;
  logic [2:0]  st_alloc_idx;
  logic        st_addr_valid = 0;
  logic [2:0]  st_addr_idx = 0;
  logic [31:0] st_addr = 0, st_data = 0;
  logic        st_commit = 0;
  logic        ld_valid = 0, ld_ready;
  logic [31:0] ld_addr = 0;
  logic [7:0]  ld_id = 0;
  logic        ld_io = 0;
  logic        res_valid, res_ready = 1, res_fwd, res_spec;
  logic [7:0]  res_id, flush_id;
  logic [31:0] res_addr, res_data;
  logic        flush_req;

  ldst_disambig dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state
  bit          m_v[8], m_k[8];
  logic [31:0] m_a[8], m_d[8];
  int          m_head = 0, m_tail = 0, m_cnt = 0;
  bit          m_pred[16];
  bit          t_v[4];
  logic [31:0] t_a[4];
  logic [7:0]  t_id[4];
  bit [7:0]    t_m[4];
  bit          e_rv = 0, e_fwd = 0, e_spec = 0, e_fl = 0;
  logic [7:0]  e_id = 0, e_fid = 0;
  logic [31:0] e_addr = 0, e_data = 0;
  string       e_tag = "R12";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unk_count();
    int n = 0;
    for (int i = 0; i < 8; i++) if (m_v[i] && !m_k[i]) n++;
    return n;
  endfunction

  task automatic cyc(bit av, bit rv, int ridx, logic [31:0] ra, logic [31:0] rd,
                     bit cm, bit lv, logic [31:0] la, logic [7:0] lid, bit lio,
                     bit rr, string tag);
    bit any_unk, hit, stall, spec, fwd, rdy, acc, rv_eff, viol, free, pop, push;
    logic [31:0] hdata;
    bit [7:0] umask;
    int vslot;
    @(negedge clk);
    // Registered outputs from the previous edge
    chk(e_tag, {31'b0, res_valid}, {31'b0, e_rv});
    if (e_rv) begin
      chk(e_tag, {31'b0, res_fwd}, {31'b0, e_fwd});
      chk(e_tag, {31'b0, res_spec}, {31'b0, e_spec});
      chk(e_tag, {24'b0, res_id}, {24'b0, e_id});
      chk(e_tag, res_addr, e_addr);
      chk(e_tag, res_data, e_data);
    end
    chk("R9", {31'b0, flush_req}, {31'b0, e_fl});
    if (e_fl) chk("R9", {24'b0, flush_id}, {24'b0, e_fid});
    st_alloc_valid = av; st_addr_valid = rv; st_addr_idx = 3'(ridx);
    st_addr = ra; st_data = rd; st_commit = cm;
    ld_valid = lv; ld_addr = la; ld_id = lid; ld_io = lio; res_ready = rr;
    #1;
    // Reference decision
    hit = 0; hdata = 0; umask = 0;
    for (int i = 0; i < 8; i++) begin
      int j = (m_head + i) % 8;
      if (m_v[j] && !m_k[j]) umask[j] = 1;
      if (m_v[j] && m_k[j] && m_a[j] == la) begin hit = 1; hdata = m_d[j]; end
    end
    any_unk = (umask != 0);
    stall = 0; spec = 0; fwd = 0;
    if (lio) stall = any_unk || hit;
    else if (any_unk) begin stall = m_pred[lid[3:0]]; spec = !stall; fwd = hit && spec; end
    else fwd = hit;
    free = !(t_v[0] && t_v[1] && t_v[2] && t_v[3]);
    rdy = !stall && (!e_rv || rr) && !rv && !(spec && !free);
    chk("R1", {31'b0, st_alloc_ready}, {31'b0, m_cnt < 8});
    chk("R1", {29'b0, st_alloc_idx}, 32'(m_tail));
    if (lv) chk(tag != "" ? tag : (lio ? "R5" : (any_unk ? "R6" : "R10")),
                {31'b0, ld_ready}, {31'b0, rdy});
    acc = lv && rdy;
    // Conflict search
    rv_eff = rv && m_v[ridx] && !m_k[ridx];
    viol = 0; vslot = 0;
    for (int t = 3; t >= 0; t--)
      if (rv_eff && t_v[t] && t_m[t][ridx] && t_a[t] == ra) begin viol = 1; vslot = t; end
    // Registered outputs for the next cycle
    e_fl = viol;
    if (viol) e_fid = t_id[vslot];
    if (acc) begin
      e_rv = 1; e_fwd = fwd; e_spec = spec; e_id = lid; e_addr = la;
      e_data = fwd ? hdata : 0;
      e_tag = (tag != "") ? tag : (spec ? "R7" : (fwd ? "R3" : "R4"));
    end else if (!e_rv || rr) e_rv = 0;
    else e_tag = "R11";
    // Tracker and predictor
    if (viol) begin
      for (int t = 0; t < 4; t++) t_v[t] = 0;
      m_pred[t_id[vslot][3:0]] = 1;
    end else begin
      if (rv_eff)
        for (int t = 0; t < 4; t++) begin
          t_m[t][ridx] = 0;
          if (t_m[t] == 0) t_v[t] = 0;
        end
      if (acc && spec) begin
        int s = 0;
        for (int t = 3; t >= 0; t--) if (!t_v[t]) s = t;
        t_v[s] = 1; t_a[s] = la; t_id[s] = lid; t_m[s] = umask;
      end
      if (acc && !spec) m_pred[lid[3:0]] = hit;
    end
    // Store buffer
    pop = cm && m_v[m_head] && m_k[m_head];
    push = av && (m_cnt < 8);
    if (pop) begin m_v[m_head] = 0; m_k[m_head] = 0; m_head = (m_head + 1) % 8; end
    if (push) begin m_v[m_tail] = 1; m_k[m_tail] = 0; m_tail = (m_tail + 1) % 8; end
    if (rv_eff) begin m_k[ridx] = 1; m_a[ridx] = ra; m_d[ridx] = rd; end
    m_cnt = m_cnt + int'(push) - int'(pop);
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R12", {31'b0, res_valid}, 0);
    chk("R12", {31'b0, flush_req}, 0);
    chk("R12", {31'b0, st_alloc_ready}, 1);
    chk("R12", {29'b0, st_alloc_idx}, 0);

    // Fill the buffer, then try one more allocation
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
    // Commit with an unresolved head is ignored
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R2");
    idle("R2");
    // Resolve all slots; slots 2 and 5 share an address
    for (int i = 0; i < 8; i++)
      cyc(0, 1, i, (i == 2 || i == 5) ? 32'h300 : 32'h200 + 4*i, 32'hD0 + i, 0, 0, 0, 0, 0, 1, "R2");
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h300, 8'h01, 0, 1, "R3");
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h404, 8'h02, 0, 1, "R4");
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h300, 8'h03, 1, 1, "R5");
    // Hold the result under back-pressure
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h204, 8'h04, 0, 0, "R11");
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h208, 8'h05, 0, 0, "R11");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R11");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R2");
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h300, 8'h03, 1, 1, "R5");
    // Speculation, conflict, training
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h500, 8'h15, 0, 1, "R7");
    cyc(0, 1, 0, 32'h500, 32'hAA, 0, 0, 0, 0, 0, 1, "R9");
    idle("R9");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R2");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h500, 8'h05, 0, 1, "R8");
    cyc(0, 1, 1, 32'h600, 32'hBB, 0, 0, 0, 0, 0, 1, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h500, 8'h05, 0, 1, "R8");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h500, 8'h05, 0, 1, "R8");
    idle("");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      bit av, rv, cm, lv, lio, rr;
      int ridx;
      av  = ($urandom % 100) < 35;
      rv  = ($urandom % 100) < 30;
      ridx = $urandom % 8;
      if (($urandom % 100) < 85 && unk_count() > 0)
        for (int k = 0; k < 8; k++) begin
          int j = (ridx + k) % 8;
          if (m_v[j] && !m_k[j]) begin ridx = j; break; end
        end
      cm  = ($urandom % 100) < 30;
      lv  = ($urandom % 100) < 55;
      lio = ($urandom % 100) < 12;
      rr  = ($urandom % 100) < 85;
      cyc(av, rv, ridx, 32'h1000 + 4*($urandom % 6), $urandom, cm, lv,
          32'h1000 + 4*($urandom % 6), 8'($urandom), lio, rr, "");
    end
    idle("");
    idle("");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule